// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequence Controller

This block sequences a 12-bit successive-approximation converter across sixteen result slots. A trigger, taken from one of four selectable sources, opens a sample window. The window ends either when the trigger drops (extended mode) or when an internal timer loaded from a 4-bit code runs out (pulse mode). A fixed 13-cycle conversion follows. Each slot holds a channel number and an end-of-sequence bit. A start-slot input chooses where a run begins. A run covers one slot (single mode) or consecutive slots up to the end-of-sequence mark (sequence mode).

The controller drives a sample-enable level, a one-cycle convert-start pulse and the channel number to the converter. At the end of each conversion it captures the converter's data word into the active slot and raises that slot's done flag. A read port returns any slot's result, and a read strobe clears that slot's flag. In pulse mode a continuous bit makes the controller chain sample/convert steps without waiting for a new trigger.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, sample_en and conv_start are low, every done flag is 0 and every slot result reads 0.
- R2: trig_src selects the trigger: 0 selects sw_trig, and 1, 2, 3 select tmr_trig[0], tmr_trig[1], tmr_trig[2]. Only a rising edge of the selected source can start a run.
- R3: With pulse_mode=0, sample_en is high from the cycle after the trigger rise is seen for as many cycles as the trigger stays high. Conversion begins in the cycle after the falling edge is seen.
- R4: With pulse_mode=1, sample_en stays high for exactly N cycles, where sample_code 0..15 gives N = 4, 8, 16, 32, 64, 96, 128, 192, 256, 384, 512, 768, then 1024 for codes 12 to 15. The trigger's falling edge has no effect.
- R5: A conversion lasts 13 cycles. It begins in the cycle right after the last sample cycle, and conv_start is high only in its first cycle. The converter's data is captured at the end of the 13th cycle.
- R6: With seq_mode=0, one conversion uses the channel in slot start_slot (slot k's channel is slot_chan[4k+3:4k]). The result goes to slot start_slot, and rd_data shows it from the next cycle.
- R7: With seq_mode=1, conversions walk through consecutive slots from start_slot, wrapping from 15 to 0. The run ends after the slot whose slot_eos bit is set. conv_chan carries the active slot's channel while sampling and converting.
- R8: With pulse_mode=1 and multi_conv=1, the next sample starts in the cycle after a result is written. In single mode the same slot repeats, and in sequence mode the walk advances up to end-of-sequence. In every other case, each further slot of a sequence waits for a new trigger rising edge.
- R9: busy is high from the first sample cycle until the cycle after the run's last result is written. It stays high while waiting for a trigger between slots. A trigger rise during sampling or conversion is ignored.
- R10: Writing a result sets that slot's done flag. rd_strobe clears the flag of slot rd_slot at the next clock. If a write and a clear hit the same slot in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_trig | input | 1 | Software/oscillator trigger (source 0) |
| tmr_trig | input | 3 | Timer trigger outputs (sources 1 to 3) |
| trig_src | input | 2 | Trigger source select |
| pulse_mode | input | 1 | 0 = trigger-width sampling, 1 = timer sampling |
| seq_mode | input | 1 | 0 = single slot, 1 = slot sequence |
| multi_conv | input | 1 | Continue without new trigger (pulse mode) |
| sample_code | input | 4 | Sample timer length code |
| start_slot | input | 4 | First slot of a run |
| slot_chan | input | 64 | Channel number per slot, 4 bits each |
| slot_eos | input | 16 | End-of-sequence bit per slot |
| conv_data | input | 12 | Result word from the converter model |
| rd_slot | input | 4 | Slot selected for reading |
| rd_strobe | input | 1 | Clear the done flag of rd_slot |
| sample_en | output | 1 | Sample/hold switch enable |
| conv_start | output | 1 | One-cycle pulse at conversion start |
| conv_chan | output | 4 | Channel of the active slot |
| busy | output | 1 | Run in progress |
| done_flags | output | 16 | Per-slot result-ready flags |
| rd_data | output | 12 | Result of slot rd_slot |

## Verification
The hardest case to reach is a done-flag clear that lands on the same edge as a new result write to that slot. The write edge is thirteen cycles after the sample window closes, and the bench does not compute it up front. Instead it holds rd_strobe high on the target slot for the whole conversion, so the collision occurs no matter where the write lands. The wrap from slot 15 to 0 and the chained steps under multi_conv are reached by starting a pulse-mode sequence at slot 14 with the end mark on slot 1. A behavioural model in the bench is compared against the ports on every clock, so ignored triggers, the per-slot waiting state and the sample window lengths are all checked cycle by cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NSLOT       = 16;
  localparam int SLOTW       = $clog2(NSLOT);
  localparam int DW          = 12;
  localparam int CHW         = 4;
  localparam int NSRC        = 4;
  localparam int CONV_CYCLES = 13;
  localparam int TCNTW       = 11;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2,
    PH_WAIT   = 2'd3
  } phase_t;

  // Length of the pulse-mode sample window in clocks.
  function automatic logic [TCNTW-1:0] sample_clocks(input logic [3:0] code);
    case (code)
      4'd0:    return TCNTW'(4);
      4'd1:    return TCNTW'(8);
      4'd2:    return TCNTW'(16);
      4'd3:    return TCNTW'(32);
      4'd4:    return TCNTW'(64);
      4'd5:    return TCNTW'(96);
      4'd6:    return TCNTW'(128);
      4'd7:    return TCNTW'(192);
      4'd8:    return TCNTW'(256);
      4'd9:    return TCNTW'(384);
      4'd10:   return TCNTW'(512);
      4'd11:   return TCNTW'(768);
      default: return TCNTW'(1024);
    endcase
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NSRC = 4,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] srcs,
  input  logic [SELW-1:0] sel,
  output logic            rise,
  output logic            fall
);
  logic lvl, lvl_q;

  assign lvl = srcs[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/adc_timing.sv
module adc_timing
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC = CONV_CYCLES,
  parameter int CNTW     = TCNTW
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_rise,
  input  logic       trig_fall,
  input  logic       pulse_mode,
  input  logic       seq_mode,
  input  logic       multi_conv,
  input  logic [3:0] sample_code,
  input  logic       last_slot,
  output phase_t     phase,
  output logic       sample_en,
  output logic       conv_start,
  output logic       wr_en,
  output logic       load_start,
  output logic       step_slot
);
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] samp_len;
  logic            samp_done;
  logic            conv_done;
  logic            auto_next;

  assign samp_len  = CNTW'(sample_clocks(sample_code));
  assign samp_done = pulse_mode ? (cnt == samp_len - CNTW'(1)) : trig_fall;
  assign conv_done = (phase == PH_CONV) && (cnt == CNTW'(CONV_CYC - 1));
  assign auto_next = pulse_mode && multi_conv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE, PH_WAIT: begin
          cnt <= '0;
          if (trig_rise) phase <= PH_SAMPLE;
        end
        PH_SAMPLE: begin
          if (samp_done) begin
            phase <= PH_CONV;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        default: begin
          if (conv_done) begin
            cnt <= '0;
            if (last_slot)
              phase <= (auto_next && !seq_mode) ? PH_SAMPLE : PH_IDLE;
            else
              phase <= auto_next ? PH_SAMPLE : PH_WAIT;
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
      endcase
    end
  end

  assign sample_en  = (phase == PH_SAMPLE);
  assign conv_start = (phase == PH_CONV) && (cnt == '0);
  assign wr_en      = conv_done;
  assign load_start = (phase == PH_IDLE) && trig_rise;
  assign step_slot  = conv_done && !last_slot;
endmodule

// File: rtl/adc_slot_store.sv
module adc_slot_store #(
  parameter int NSLOT = 16,
  parameter int DW    = 12,
  localparam int SLOTW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SLOTW-1:0] wr_slot,
  input  logic [DW-1:0]    wr_data,
  input  logic [SLOTW-1:0] rd_slot,
  input  logic             rd_strobe,
  output logic [DW-1:0]    rd_data,
  output logic [NSLOT-1:0] done_flags
);
  logic [DW-1:0] mem [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic hit_wr, hit_rd;
    assign hit_wr = wr_en && (wr_slot == SLOTW'(k));
    assign hit_rd = rd_strobe && (rd_slot == SLOTW'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[k]        <= '0;
        done_flags[k] <= 1'b0;
      end else begin
        if (hit_wr) mem[k] <= wr_data;
        if (hit_wr)      done_flags[k] <= 1'b1;
        else if (hit_rd) done_flags[k] <= 1'b0;
      end
    end
  end

  assign rd_data = mem[rd_slot];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_SLOT   = NSLOT,
  parameter int DATA_W   = DW,
  parameter int CHAN_W   = CHW,
  parameter int N_SRC    = NSRC,
  parameter int CONV_CYC = CONV_CYCLES,
  localparam int SW      = $clog2(N_SLOT),
  localparam int SRCW    = $clog2(N_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_trig,
  input  logic [N_SRC-2:0]         tmr_trig,
  input  logic [SRCW-1:0]          trig_src,
  input  logic                     pulse_mode,
  input  logic                     seq_mode,
  input  logic                     multi_conv,
  input  logic [3:0]               sample_code,
  input  logic [SW-1:0]            start_slot,
  input  logic [N_SLOT*CHAN_W-1:0] slot_chan,
  input  logic [N_SLOT-1:0]        slot_eos,
  input  logic [DATA_W-1:0]        conv_data,
  input  logic [SW-1:0]            rd_slot,
  input  logic                     rd_strobe,
  output logic                     sample_en,
  output logic                     conv_start,
  output logic [CHAN_W-1:0]        conv_chan,
  output logic                     busy,
  output logic [N_SLOT-1:0]        done_flags,
  output logic [DATA_W-1:0]        rd_data
);
  // Named internal events, also observed by the bound checker.
  logic          trig_rise, trig_fall;
  logic          wr_en, load_start, step_slot, last_slot;
  logic [SW-1:0] slot_q;
  phase_t        phase;

  adc_trig_sel #(.NSRC(N_SRC)) u_trig (
    .clk  (clk),
    .rst_n(rst_n),
    .srcs ({tmr_trig, sw_trig}),
    .sel  (trig_src),
    .rise (trig_rise),
    .fall (trig_fall)
  );

  adc_timing #(.CONV_CYC(CONV_CYC), .CNTW(TCNTW)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_rise  (trig_rise),
    .trig_fall  (trig_fall),
    .pulse_mode (pulse_mode),
    .seq_mode   (seq_mode),
    .multi_conv (multi_conv),
    .sample_code(sample_code),
    .last_slot  (last_slot),
    .phase      (phase),
    .sample_en  (sample_en),
    .conv_start (conv_start),
    .wr_en      (wr_en),
    .load_start (load_start),
    .step_slot  (step_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          slot_q <= '0;
    else if (load_start) slot_q <= start_slot;
    else if (step_slot)  slot_q <= slot_q + SW'(1);
  end

  assign conv_chan = slot_chan[slot_q*CHAN_W +: CHAN_W];
  assign last_slot = !seq_mode || slot_eos[slot_q];
  assign busy      = (phase != PH_IDLE);

  adc_slot_store #(.NSLOT(N_SLOT), .DW(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_slot   (slot_q),
    .wr_data   (conv_data),
    .rd_slot   (rd_slot),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .done_flags(done_flags)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int N_SLOT = 16,
  localparam int SW = $clog2(N_SLOT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_en,
  input logic              conv_start,
  input logic              busy,
  input logic [N_SLOT-1:0] done_flags,
  input logic              wr_en,
  input logic [SW-1:0]     wr_slot,
  input logic              rd_strobe,
  input logic [SW-1:0]     rd_slot
);
  assert_conv_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(sample_en));

  assert_conv_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_busy_ends_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wr_en));

  assert_run_starts_sampling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sample_en);

  assert_done_set_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done_flags[$past(wr_slot)]);

  assert_done_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !(wr_en && wr_slot == rd_slot)) |=> !done_flags[$past(rd_slot)]);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.N_SLOT(N_SLOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_en (sample_en),
  .conv_start(conv_start),
  .busy      (busy),
  .done_flags(done_flags),
  .wr_en     (wr_en),
  .wr_slot   (slot_q),
  .rd_strobe (rd_strobe),
  .rd_slot   (rd_slot)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  trig_vec = '0;
  logic [1:0]  trig_src = '0;
  logic        pulse_mode = 0, seq_mode = 0, multi_conv = 0;
  logic [3:0]  sample_code = '0, start_slot = '0, rd_slot = '0;
  logic        rd_strobe = 0;
  logic [63:0] slot_chan;
  logic [15:0] slot_eos = '0;
  logic [11:0] conv_data, rd_data;
  logic        sample_en, conv_start, busy;
  logic [3:0]  conv_chan;
  logic [15:0] done_flags;
  logic [3:0]  chan_cfg [16];

  int n_checks = 0, n_fail = 0;
  bit checking = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int k = 0; k < 16; k++) slot_chan[k*4 +: 4] = chan_cfg[k];

  function automatic int win_len(int c);
    if (c >= 12) return 1024;
    if (c <= 3) return 4 << c;
    if (c % 2 == 0) return 64 << ((c - 4) / 2);
    return 96 << ((c - 5) / 2);
  endfunction

  function automatic logic [11:0] adc_model(logic [3:0] ch);
    return 12'((int'(ch) * 337 + 91) % 4096);
  endfunction

  assign conv_data = adc_model(conv_chan);

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sw_trig(trig_vec[0]), .tmr_trig(trig_vec[3:1]),
    .trig_src(trig_src), .pulse_mode(pulse_mode), .seq_mode(seq_mode),
    .multi_conv(multi_conv), .sample_code(sample_code), .start_slot(start_slot),
    .slot_chan(slot_chan), .slot_eos(slot_eos), .conv_data(conv_data),
    .rd_slot(rd_slot), .rd_strobe(rd_strobe), .sample_en(sample_en),
    .conv_start(conv_start), .conv_chan(conv_chan), .busy(busy),
    .done_flags(done_flags), .rd_data(rd_data)
  );

  // Behavioural reference: 0 idle, 1 sampling, 2 converting, 3 waiting.
  int          m_ph = 0, m_left = 0, m_slot = 0;
  bit          m_trig = 0;
  logic [11:0] m_mem [16];
  bit          m_done [16];

  always @(posedge clk) begin
    bit cur, rise, fall, last;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_slot = 0; m_trig = 0;
      for (int k = 0; k < 16; k++) begin m_mem[k] = '0; m_done[k] = 0; end
    end else begin
      cur = trig_vec[trig_src];
      rise = cur && !m_trig;
      fall = !cur && m_trig;
      m_trig = cur;
      if (rd_strobe) m_done[rd_slot] = 0;
      case (m_ph)
        0: if (rise) begin m_slot = start_slot; m_ph = 1; m_left = win_len(sample_code); end
        1: begin
          if (pulse_mode) begin
            if (m_left == 1) begin m_ph = 2; m_left = 13; end
            else m_left--;
          end else if (fall) begin m_ph = 2; m_left = 13; end
        end
        2: begin
          if (m_left == 1) begin
            m_mem[m_slot] = adc_model(chan_cfg[m_slot]);
            m_done[m_slot] = 1;
            last = !seq_mode || slot_eos[m_slot];
            if (!last) m_slot = (m_slot + 1) % 16;
            if (pulse_mode && multi_conv && !(last && seq_mode)) begin
              m_ph = 1; m_left = win_len(sample_code);
            end else m_ph = last ? 0 : 3;
          end else m_left--;
        end
        default: if (rise) begin m_ph = 1; m_left = win_len(sample_code); end
      endcase
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] exp_done;
    if (rst_n && checking) begin
      for (int k = 0; k < 16; k++) exp_done[k] = m_done[k];
      chk(busy === (m_ph != 0), "R9 busy", busy, m_ph != 0);
      chk(sample_en === (m_ph == 1), pulse_mode ? "R4 sample_en" : "R3 sample_en",
          sample_en, m_ph == 1);
      chk(conv_start === (m_ph == 2 && m_left == 13), "R5 conv_start", conv_start,
          m_ph == 2 && m_left == 13);
      chk(done_flags === exp_done, "R10 done_flags", done_flags, exp_done);
      chk(rd_data === m_mem[rd_slot], "R6 rd_data", rd_data, m_mem[rd_slot]);
      if (m_ph == 1 || m_ph == 2)
        chk(conv_chan === chan_cfg[m_slot], "R7 conv_chan", conv_chan, chan_cfg[m_slot]);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_trig(int idx, int hi);
    step(1);
    trig_vec[idx] = 1'b1;
    step(hi);
    trig_vec[idx] = 1'b0;
  endtask

  task automatic wait_idle(int maxc, string tag);
    bit seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!busy) begin seen = 1; break; end
    end
    #1;
    chk(seen, tag, busy, 0);
  endtask

  bit run_done = 0;

  initial begin
    for (int k = 0; k < 16; k++) chan_cfg[k] = 4'(15 - k);
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    chk(busy === 0 && sample_en === 0 && conv_start === 0, "R1 control idle", busy, 0);
    chk(done_flags === 16'h0, "R1 done flags", done_flags, 0);
    chk(rd_data === 12'h0, "R1 result", rd_data, 0);
    checking = 1;

    // R3/R6: extended single on slot 3, second trigger rise while converting ignored (R9)
    start_slot = 4'd3; rd_slot = 4'd3;
    pulse_trig(0, 5);
    step(4);
    pulse_trig(0, 2);
    wait_idle(100, "R6 single extended finish");
    chk(rd_data === adc_model(chan_cfg[3]), "R6 slot 3 result", rd_data, adc_model(chan_cfg[3]));
    rd_strobe = 1; step(1); rd_strobe = 0; step(1);
    chk(done_flags[3] === 1'b0, "R10 clear slot 3", done_flags[3], 0);

    // R2: unselected source ignored, then the selected one
    trig_src = 2'd2; start_slot = 4'd7;
    pulse_trig(1, 3);
    step(2);
    chk(busy === 1'b0, "R2 unselected source", busy, 0);
    pulse_trig(2, 3);
    wait_idle(100, "R2 selected source run");

    // R7/R8: pulse sequence with wrap 14,15,0,1 under multi_conv
    pulse_mode = 1; seq_mode = 1; multi_conv = 1; sample_code = 4'd0;
    start_slot = 4'd14; slot_eos = 16'h0002; trig_src = 2'd0; rd_slot = 4'd0;
    pulse_trig(0, 1);
    wait_idle(200, "R8 chained sequence");
    chk(done_flags[15:14] === 2'b11 && done_flags[1:0] === 2'b11, "R7 wrap flags",
        done_flags, 16'hC003);

    // R8: without multi_conv each slot waits for a trigger; triggers mid-step ignored (R9)
    multi_conv = 0; start_slot = 4'd5; slot_eos = 16'h0040; sample_code = 4'd1;
    pulse_trig(0, 1);
    step(5);
    pulse_trig(0, 1);
    step(30);
    chk(busy === 1'b1, "R8 waiting between slots", busy, 1);
    pulse_trig(0, 2);
    wait_idle(100, "R8 triggered second slot");

    // R8: single slot repeats under multi_conv until it is cleared
    seq_mode = 0; multi_conv = 1; sample_code = 4'd0; start_slot = 4'd9; rd_slot = 4'd9;
    pulse_trig(0, 1);
    step(60);
    multi_conv = 0;
    wait_idle(100, "R8 repeat stops");

    // R4: longer timer codes
    sample_code = 4'd5;
    pulse_trig(0, 1);
    wait_idle(300, "R4 code 5");
    sample_code = 4'd13;
    pulse_trig(0, 1);
    wait_idle(1200, "R4 code 13");

    // R10: clear held across the write to the same slot
    start_slot = 4'd4; rd_slot = 4'd4; sample_code = 4'd0; rd_strobe = 1;
    pulse_trig(0, 1);
    wait_idle(100, "R10 collision run");
    rd_strobe = 0;
    step(2);

    // R3/R7: extended-mode sequence 0..2, one trigger per slot
    pulse_mode = 0; seq_mode = 1; start_slot = 4'd0; slot_eos = 16'h0004; rd_slot = 4'd2;
    pulse_trig(3, 1); trig_src = 2'd3;
    for (int s = 0; s < 3; s++) begin
      pulse_trig(3, 3 + s);
      step(20);
    end
    wait_idle(50, "R7 extended sequence");
    chk(rd_data === adc_model(chan_cfg[2]), "R7 last slot result", rd_data, adc_model(chan_cfg[2]));

    step(3);
    run_done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule